// File: doc/BRIEF.md
# Nibble-Serial Sixteen-Bit ALU

This block gives a datapath a complete 16-bit arithmetic and logic unit while holding only a single 4-bit slice of combinational ALU logic. When a start request arrives, the block captures both operands, the operation code and the external carry. It then sends one 4-bit piece of the operands through the slice on each clock. A one-bit link register carries the carry, or the bit that crosses a nibble boundary during a shift, from one slice step to the next. Each slice output is shifted into a result register. After four steps the full word is in that register, together with a carry flag and a zero flag.

Arithmetic and left shift start at the least significant nibble and ripple upward. Right shift starts at the most significant nibble, so the bit that leaves the bottom of one nibble enters the top of the next lower nibble. A controller uses the block by raising `start_i` for one cycle while `busy_o` is low and then waiting for the one-cycle `done_o` pulse. The result and both flags stay unchanged after that pulse until the next accepted start.

Top module: `nsa_core`

## Requirements
- R1: Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 decrement, 5 decrement with carry, 6 AND, 7 NAND, 8 OR, 9 NOR, 10 XOR, 11 shift left, 12 shift right, 13 to 15 pass A. Code 0 gives A+B. Code 1 gives A+B+cin. For both, `cy_o` is the carry out of bit 15.
- R2: Subtract (code 2) gives A + ~B + 1. Subtract with carry (code 3) gives A + ~B + cin. For both, `cy_o` is the carry out of bit 15, so it is 1 when no borrow occurred.
- R3: Decrement (code 4) gives A + 0xFFFF. Decrement with carry (code 5) gives A + 0xFFFF + cin. For both, `cy_o` is the carry out of bit 15.
- R4: Codes 6 to 10 give the bitwise AND, NAND, OR, NOR and XOR of A and B. For these codes `cy_o` is 0.
- R5: Shift left (code 11) gives {A[14:0], cin}, with `cy_o` = A[15].
- R6: Shift right (code 12) gives {cin, A[15:1]}, with `cy_o` = A[0]. The crossing bit moves from each nibble into the top of the next lower nibble.
- R7: When `done_o` is high, `zf_o` is 1 exactly when `res_o` is 0.
- R8: A start accepted at a clock edge makes `busy_o` high for exactly the next four cycles. `done_o` is then high for one cycle, in which `res_o`, `cy_o` and `zf_o` already hold the final values.
- R9: A start raised while `busy_o` is high is ignored. The running operation keeps its timing and its result.
- R10: Operands, code and carry are captured when the start is accepted, and later changes on those inputs do not affect the operation. While idle with no start, `res_o`, `cy_o` and `zf_o` hold their values.
- R11: A synchronous high `rst` makes the block idle, with `busy_o`=0, `done_o`=0, `res_o`=0, `cy_o`=0, `zf_o`=1. The carry link is cleared.
- R12: Codes 13 to 15 return A unchanged, with `cy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation; taken only while idle |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| cin_i | input | 1 | External carry, or the bit shifted in |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| res_o | output | 16 | Result word |
| cy_o | output | 1 | Carry flag, or the bit shifted out |
| zf_o | output | 1 | Zero flag |

## Verification
A carry link that fails to move between slices corrupts only the upper nibbles, so random stimulus would rarely catch it. Directed carry-chain cases therefore propagate a carry through all four nibbles (0xFFFF+1, 0-1, decrement of 0). A wrong slice order or nibble index shows up on the `done_o` cycle as swapped nibbles or a misplaced shifted bit. A wrong step count shows up at the ports as a busy window of other than four cycles or a displaced done pulse.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

    localparam int WORD_W  = 16;
    localparam int SLICE_W = 4;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_ADC  = 4'd1;
    localparam logic [3:0] OP_SUB  = 4'd2;
    localparam logic [3:0] OP_SBC  = 4'd3;
    localparam logic [3:0] OP_DEC  = 4'd4;
    localparam logic [3:0] OP_DCC  = 4'd5;
    localparam logic [3:0] OP_AND  = 4'd6;
    localparam logic [3:0] OP_NAND = 4'd7;
    localparam logic [3:0] OP_OR   = 4'd8;
    localparam logic [3:0] OP_NOR  = 4'd9;
    localparam logic [3:0] OP_XOR  = 4'd10;
    localparam logic [3:0] OP_SHL  = 4'd11;
    localparam logic [3:0] OP_SHR  = 4'd12;

    typedef enum logic [1:0] {K_ARITH, K_LOGIC, K_SHIFT, K_PASS} kind_e;
    typedef enum logic [2:0] {L_AND, L_NAND, L_OR, L_NOR, L_XOR} lfn_e;
    typedef enum logic [1:0] {B_TRUE, B_INV, B_ONES} bsel_e;
    typedef enum logic [1:0] {C_ZERO, C_ONE, C_EXT} csrc_e;

    typedef struct packed {
        kind_e kind;
        bsel_e bsel;
        csrc_e csrc;
        lfn_e  lfn;
        logic  msb_first;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [3:0] op);
        ctl_t c;
        c.kind      = K_PASS;
        c.bsel      = B_TRUE;
        c.csrc      = C_ZERO;
        c.lfn       = L_AND;
        c.msb_first = 1'b0;
        case (op)
            OP_ADD:  c.kind = K_ARITH;
            OP_ADC:  begin c.kind = K_ARITH; c.csrc = C_EXT; end
            OP_SUB:  begin c.kind = K_ARITH; c.bsel = B_INV;  c.csrc = C_ONE; end
            OP_SBC:  begin c.kind = K_ARITH; c.bsel = B_INV;  c.csrc = C_EXT; end
            OP_DEC:  begin c.kind = K_ARITH; c.bsel = B_ONES; end
            OP_DCC:  begin c.kind = K_ARITH; c.bsel = B_ONES; c.csrc = C_EXT; end
            OP_AND:  begin c.kind = K_LOGIC; c.lfn = L_AND;  end
            OP_NAND: begin c.kind = K_LOGIC; c.lfn = L_NAND; end
            OP_OR:   begin c.kind = K_LOGIC; c.lfn = L_OR;   end
            OP_NOR:  begin c.kind = K_LOGIC; c.lfn = L_NOR;  end
            OP_XOR:  begin c.kind = K_LOGIC; c.lfn = L_XOR;  end
            OP_SHL:  begin c.kind = K_SHIFT; c.csrc = C_EXT; end
            OP_SHR:  begin c.kind = K_SHIFT; c.csrc = C_EXT; c.msb_first = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic first_link(input ctl_t c, input logic cin);
        case (c.csrc)
            C_ONE:   return 1'b1;
            C_EXT:   return cin;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic keeps_carry(input ctl_t c);
        return (c.kind == K_ARITH) || (c.kind == K_SHIFT);
    endfunction

endpackage

// File: rtl/nsa_slice.sv
module nsa_slice
    import nsa_pkg::*;
#(
    parameter int SLICE_W = nsa_pkg::SLICE_W
) (
    input  ctl_t               ctl,
    input  logic [SLICE_W-1:0] a_n,
    input  logic [SLICE_W-1:0] b_n,
    input  logic               c_in,
    output logic [SLICE_W-1:0] y_n,
    output logic               c_out
);

    logic [SLICE_W-1:0] b_x;
    logic [SLICE_W:0]   sum;
    logic [SLICE_W-1:0] lres;

    always_comb begin
        case (ctl.bsel)
            B_INV:   b_x = ~b_n;
            B_ONES:  b_x = '1;
            default: b_x = b_n;
        endcase
        sum = {1'b0, a_n} + {1'b0, b_x} + {{SLICE_W{1'b0}}, c_in};
    end

    always_comb begin
        case (ctl.lfn)
            L_NAND:  lres = ~(a_n & b_n);
            L_OR:    lres = a_n | b_n;
            L_NOR:   lres = ~(a_n | b_n);
            L_XOR:   lres = a_n ^ b_n;
            default: lres = a_n & b_n;
        endcase
    end

    always_comb begin
        case (ctl.kind)
            K_ARITH: begin
                y_n   = sum[SLICE_W-1:0];
                c_out = sum[SLICE_W];
            end
            K_LOGIC: begin
                y_n   = lres;
                c_out = 1'b0;
            end
            K_SHIFT: begin
                if (ctl.msb_first) begin
                    y_n   = {c_in, a_n[SLICE_W-1:1]};
                    c_out = a_n[0];
                end else begin
                    y_n   = {a_n[SLICE_W-2:0], c_in};
                    c_out = a_n[SLICE_W-1];
                end
            end
            default: begin
                y_n   = a_n;
                c_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nsa_seq.sv
module nsa_seq #(
    parameter int NSLICE = 4,
    localparam int CW    = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          last,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_END = CW'(NSLICE - 1);

    assign accept = start & ~busy;
    assign last   = busy & (cnt == CNT_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nsa_collect.sv
module nsa_collect #(
    parameter int WORD_W  = nsa_pkg::WORD_W,
    parameter int SLICE_W = nsa_pkg::SLICE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic               msb_first,
    input  logic               keep_cy,
    input  logic               c_init,
    input  logic [SLICE_W-1:0] y_n,
    input  logic               c_nxt,
    output logic               link,
    output logic [WORD_W-1:0]  res,
    output logic               cy,
    output logic               zf
);

    logic zacc;
    logic y_zero;

    assign y_zero = ~|y_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            link <= 1'b0;
            res  <= '0;
            cy   <= 1'b0;
            zf   <= 1'b1;
            zacc <= 1'b1;
        end else if (load) begin
            link <= c_init;
            zacc <= 1'b1;
        end else if (step) begin
            link <= c_nxt;
            zacc <= zacc & y_zero;
            if (msb_first) begin
                res <= {res[WORD_W-SLICE_W-1:0], y_n};
            end else begin
                res <= {y_n, res[WORD_W-1:SLICE_W]};
            end
            if (last) begin
                cy <= keep_cy & c_nxt;
                zf <= zacc & y_zero;
            end
        end
    end

endmodule

// File: rtl/nsa_core.sv
module nsa_core
    import nsa_pkg::*;
#(
    parameter int WORD_W  = nsa_pkg::WORD_W,
    parameter int SLICE_W = nsa_pkg::SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic              cin_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] res_o,
    output logic              cy_o,
    output logic              zf_o
);

    localparam int NSLICE = WORD_W / SLICE_W;
    localparam int CW     = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam logic [CW-1:0] TOP_IDX = CW'(NSLICE - 1);

    logic              accept;
    logic              last;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     idx;
    logic [WORD_W-1:0] a_q;
    logic [WORD_W-1:0] b_q;
    ctl_t              ctl_q;
    ctl_t              ctl_in;
    logic              link;
    logic [SLICE_W-1:0] a_nib [NSLICE];
    logic [SLICE_W-1:0] b_nib [NSLICE];
    logic [SLICE_W-1:0] y_n;
    logic              c_nxt;

    assign ctl_in = decode_op(op_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            ctl_q <= decode_op(4'd0);
        end else if (accept) begin
            a_q   <= opa_i;
            b_q   <= opb_i;
            ctl_q <= ctl_in;
        end
    end

    generate
        for (genvar g = 0; g < NSLICE; g++) begin : g_nib
            assign a_nib[g] = a_q[g*SLICE_W +: SLICE_W];
            assign b_nib[g] = b_q[g*SLICE_W +: SLICE_W];
        end
    endgenerate

    assign idx = ctl_q.msb_first ? (TOP_IDX - cnt) : cnt;

    nsa_seq #(.NSLICE(NSLICE)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .busy   (busy_o),
        .done   (done_o),
        .accept (accept),
        .last   (last),
        .cnt    (cnt)
    );

    nsa_slice #(.SLICE_W(SLICE_W)) u_slice (
        .ctl   (ctl_q),
        .a_n   (a_nib[idx]),
        .b_n   (b_nib[idx]),
        .c_in  (link),
        .y_n   (y_n),
        .c_out (c_nxt)
    );

    nsa_collect #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_col (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (busy_o),
        .last      (last),
        .msb_first (ctl_q.msb_first),
        .keep_cy   (keeps_carry(ctl_q)),
        .c_init    (first_link(ctl_in, cin_i)),
        .y_n       (y_n),
        .c_nxt     (c_nxt),
        .link      (link),
        .res       (res_o),
        .cy        (cy_o),
        .zf        (zf_o)
    );

endmodule

// File: rtl/nsa_core_chk.sv
module nsa_core_chk #(
    parameter int WORD_W  = 16,
    parameter int SLICE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [3:0]        op_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] res_o,
    input logic              cy_o,
    input logic              zf_o
);

    localparam int NSLICE = WORD_W / SLICE_W;

    logic [7:0] bcnt;
    logic       nocarry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt      <= '0;
            nocarry_q <= 1'b0;
        end else begin
            bcnt <= busy_o ? bcnt + 8'd1 : 8'd0;
            if (start_i && !busy_o) begin
                nocarry_q <= (op_i >= 4'd6 && op_i <= 4'd10) || (op_i >= 4'd13);
            end
        end
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (bcnt == 8'(NSLICE)));

    // R8
    busy_max_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (bcnt < 8'(NSLICE)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (zf_o == (res_o == '0)));

    // R4
    logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && nocarry_q) |-> !cy_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(res_o) && $stable(cy_o) && $stable(zf_o)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && res_o == '0 && !cy_o && zf_o));

endmodule

bind nsa_core nsa_core_chk #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .op_i    (op_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .res_o   (res_o),
    .cy_o    (cy_o),
    .zf_o    (zf_o)
);

// File: tb/nsa_core_tb.sv
`timescale 1ns/1ps
module nsa_core_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [3:0]  op_i;
    logic [15:0] opa_i;
    logic [15:0] opb_i;
    logic        cin_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] res_o;
    logic        cy_o;
    logic        zf_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    nsa_core u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i),
        .busy_o(busy_o), .done_o(done_o), .res_o(res_o),
        .cy_o(cy_o), .zf_o(zf_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // returns {carry, result}
    function automatic logic [16:0] model(input logic [3:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic c);
        logic [16:0] s;
        case (op)
            4'd0:  s = {1'b0, a} + {1'b0, b};
            4'd1:  s = {1'b0, a} + {1'b0, b} + 17'(c);
            4'd2:  s = {1'b0, a} + {1'b0, ~b} + 17'd1;
            4'd3:  s = {1'b0, a} + {1'b0, ~b} + 17'(c);
            4'd4:  s = {1'b0, a} + 17'h0FFFF;
            4'd5:  s = {1'b0, a} + 17'h0FFFF + 17'(c);
            4'd6:  s = {1'b0, a & b};
            4'd7:  s = {1'b0, ~(a & b)};
            4'd8:  s = {1'b0, a | b};
            4'd9:  s = {1'b0, ~(a | b)};
            4'd10: s = {1'b0, a ^ b};
            4'd11: s = {a[15], a[14:0], c};
            4'd12: s = {a[0], c, a[15:1]};
            default: s = {1'b0, a};
        endcase
        return s;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:  return "R1";
            4'd2, 4'd3:  return "R2";
            4'd4, 4'd5:  return "R3";
            4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return "R4";
            4'd11: return "R5";
            4'd12: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [15:0] a,
                          input logic [15:0] b, input logic c, input bit poke);
        logic [16:0] exp;
        string tg;
        exp = model(op, a, b, c);
        tg  = tag_of(op);
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b; cin_i = c;
        @(negedge clk);
        // R10: scramble inputs after capture
        start_i = 1'b0; op_i = 4'($urandom); opa_i = 16'($urandom);
        opb_i = 16'($urandom); cin_i = 1'($urandom);
        check(busy_o === 1'b1 && done_o === 1'b0, "R8", "busy after start",
              {busy_o, done_o}, 2'b10);
        for (int i = 1; i < 4; i++) begin
            if (poke && i == 1) begin
                // R9: start while busy
                start_i = 1'b1; op_i = 4'($urandom); opa_i = 16'($urandom);
            end
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o === 1'b1 && done_o === 1'b0, poke ? "R9" : "R8",
                  "busy window", {busy_o, done_o}, 2'b10);
        end
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b1, "R8", "done pulse",
              {busy_o, done_o}, 2'b01);
        check(res_o === exp[15:0], tg, "result", res_o, exp[15:0]);
        check(cy_o === exp[16], tg, "carry", cy_o, exp[16]);
        check(zf_o === (exp[15:0] == 16'd0), "R7", "zero flag", zf_o, exp[15:0] == 16'd0);
        @(negedge clk);
        check(done_o === 1'b0 && res_o === exp[15:0] && cy_o === exp[16], "R10",
              "hold after done", {done_o, cy_o, res_o}, {1'b0, exp[16], exp[15:0]});
    endtask

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0; cin_i = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy_o === 1'b0 && done_o === 1'b0 && res_o === 16'd0 && cy_o === 1'b0
              && zf_o === 1'b1, "R11", "reset state",
              {busy_o, done_o, cy_o, zf_o, res_o}, {4'b0001, 16'd0});
        rst = 1'b0;

        // directed corners
        run_op(4'd0,  16'hFFFF, 16'h0001, 1'b0, 1'b0); // R1 full ripple
        run_op(4'd1,  16'h00FF, 16'h0000, 1'b1, 1'b0); // R1 carry-in
        run_op(4'd2,  16'h5A5A, 16'h5A5A, 1'b0, 1'b1); // R2 equal
        run_op(4'd2,  16'h0000, 16'h0001, 1'b1, 1'b0); // R2 borrow
        run_op(4'd3,  16'h1000, 16'h0001, 1'b0, 1'b0); // R2 sbc
        run_op(4'd4,  16'h0000, 16'h1234, 1'b1, 1'b0); // R3 dec zero
        run_op(4'd4,  16'h0001, 16'h0000, 1'b0, 1'b0); // R3 dec to zero
        run_op(4'd5,  16'h1234, 16'h0000, 1'b1, 1'b0); // R3 dcc keeps
        run_op(4'd10, 16'hC3C3, 16'hC3C3, 1'b1, 1'b0); // R4 xor zero
        run_op(4'd9,  16'h0000, 16'h0000, 1'b1, 1'b0); // R4 nor
        run_op(4'd11, 16'h8001, 16'h0000, 1'b1, 1'b1); // R5
        run_op(4'd12, 16'h8001, 16'hFFFF, 1'b0, 1'b0); // R6
        run_op(4'd12, 16'h0010, 16'h0000, 1'b1, 1'b0); // R6 crossing bit
        run_op(4'd14, 16'hBEEF, 16'h1111, 1'b1, 1'b0); // R12

        // reset during an operation: R11
        @(negedge clk);
        start_i = 1'b1; op_i = 4'd0; opa_i = 16'h1111; opb_i = 16'h2222; cin_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy_o === 1'b0 && done_o === 1'b0 && res_o === 16'd0 && cy_o === 1'b0
              && zf_o === 1'b1, "R11", "mid-op reset",
              {busy_o, done_o, cy_o, zf_o, res_o}, {4'b0001, 16'd0});

        // constrained random
        for (int n = 0; n < 200; n++) begin
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                   1'($urandom), ($urandom_range(0, 3) == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule